// File: doc/BRIEF.md
# Serial Word Copy Between Two Shift Registers

This block keeps two equal-width registers, a source and a destination, and copies the source word into the destination over one serial line. On each shift clock the source register rotates right: the bit that leaves its low end re-enters at its high end. At the same time the destination shifts right and takes the source's outgoing low bit in at its high end. After one word length of shifts the destination holds the source's word, and the source is back at its starting value.

Both registers are first loaded in parallel. A start pulse then begins the copy. A small counter lets the shift enable through for exactly WIDTH cycles. The block then holds both registers and raises a one-cycle completion pulse. The clock is never gated; shifting stops only because the enable drops. A start or a load that arrives while a copy is running has no effect.

Top module: `loopback_xfer`

## Requirements
- R1: A synchronous reset clears both registers and the done output, and returns the block to idle.
- R2: While idle, load high copies loadA into regA and loadB into regB at the next edge. While a copy is running, load has no effect.
- R3: On every shift edge regA rotates right: regA[WIDTH-1] takes the old regA[0], and each other bit i takes the old bit i+1.
- R4: On every shift edge regB shifts right: regB[WIDTH-1] takes the old regA[0], and each other bit i takes the old bit i+1. With WIDTH=4, A=1011 and B=0011, the states are A 1011,1101,1110,0111,1011 and B 0011,1001,1100,0110,1011.
- R5: A start seen while idle gives exactly WIDTH shift edges. The first shift is on the edge after the one that samples start. Done rises on the same edge as the last shift.
- R6: When a copy completes, regB equals the word regA held at start, and regA again holds that word.
- R7: A start that arrives while a copy is running is ignored. The running copy still ends after its own WIDTH shifts.
- R8: While idle with load low, both registers hold their values.
- R9: Done is high for exactly one cycle per completed copy. The block accepts a new start in the cycle when done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Parallel load strobe for both registers |
| loadA | input | WIDTH | Parallel value for the source register |
| loadB | input | WIDTH | Parallel value for the destination register |
| start | input | 1 | Begins a copy when the block is idle |
| done | output | 1 | One-cycle pulse when a copy completes |
| regA | output | WIDTH | Source register contents |
| regB | output | WIDTH | Destination register contents |

## Verification
The bench builds the block with the default WIDTH of 4. At that width all 16 source words can be copied, each over a destination of its complement, and the 2-bit shift counter wraps on every copy. This small width also leaves room for the following cases:
- the known four-step state sequence;
- a load and a start in the same cycle;
- a start or a load during a copy;
- a start on the done cycle;
- a reset in the middle of a copy.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  // Strobes from control to datapath; at most one is high in any cycle
  typedef struct packed {
    logic loadEn;
    logic shiftEn;
  } xferCtl_t;
endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  logic     start,
  output xferCtl_t ctl,
  output logic     done
);
  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic             busy;
  logic [CNT_W-1:0] shiftCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      shiftCnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (shiftCnt == LAST) begin
          busy     <= 1'b0;
          shiftCnt <= '0;
          done     <= 1'b1;
        end else begin
          shiftCnt <= shiftCnt + 1'b1;
        end
      end else if (start) begin
        busy     <= 1'b1;
        shiftCnt <= '0;
      end
    end
  end

  always_comb begin
    ctl.loadEn  = load & ~busy;
    ctl.shiftEn = busy;
  end
endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  xferCtl_t         ctl,
  input  logic [WIDTH-1:0] loadA,
  input  logic [WIDTH-1:0] loadB,
  output logic [WIDTH-1:0] regA,
  output logic [WIDTH-1:0] regB
);
  // One cell per bit position; the top cell takes the source's low bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    localparam int SRC = (i == WIDTH - 1) ? 0 : i + 1;
    always_ff @(posedge clk) begin
      if (rst) begin
        regA[i] <= 1'b0;
        regB[i] <= 1'b0;
      end else if (ctl.loadEn) begin
        regA[i] <= loadA[i];
        regB[i] <= loadB[i];
      end else if (ctl.shiftEn) begin
        regA[i] <= regA[SRC];
        regB[i] <= (i == WIDTH - 1) ? regA[0] : regB[SRC];
      end
    end
  end
endmodule

// File: rtl/loopback_xfer.sv
module loopback_xfer
  import xfer_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] loadA,
  input  logic [WIDTH-1:0] loadB,
  input  logic             start,
  output logic             done,
  output logic [WIDTH-1:0] regA,
  output logic [WIDTH-1:0] regB
);
  xferCtl_t ctl;

  xfer_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .load(load), .start(start), .ctl(ctl), .done(done)
  );

  xfer_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .loadA(loadA), .loadB(loadB),
    .regA(regA), .regB(regB)
  );
endmodule

// File: rtl/loopback_xfer_chk.sv
module loopback_xfer_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             loadEn,
  input logic             shiftEn,
  input logic             done,
  input logic [WIDTH-1:0] regA,
  input logic [WIDTH-1:0] regB
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (regA == '0 && regB == '0 && !done));

  // R3
  rotate_a_chk: assert property (@(posedge clk) disable iff (rst)
    shiftEn |=> regA == {$past(regA[0]), $past(regA[WIDTH-1:1])});

  // R4
  shift_b_chk: assert property (@(posedge clk) disable iff (rst)
    shiftEn |=> regB == {$past(regA[0]), $past(regB[WIDTH-1:1])});

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!shiftEn && !loadEn) |=> ($stable(regA) && $stable(regB)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  done_after_shift_chk: assert property (@(posedge clk) disable iff (rst)
    shiftEn && !$past(shiftEn) |-> !done || $past(done));

  // R2
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(loadEn && shiftEn));
endmodule

bind loopback_xfer loopback_xfer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .loadEn(ctl.loadEn), .shiftEn(ctl.shiftEn),
  .done(done), .regA(regA), .regB(regB)
);

// File: tb/loopback_xfer_tb.sv
module loopback_xfer_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] loadA = '0;
  logic [W-1:0] loadB = '0;
  logic         start = 1'b0;
  logic         done;
  logic [W-1:0] regA;
  logic [W-1:0] regB;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  loopback_xfer #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .load(load), .loadA(loadA), .loadB(loadB),
    .start(start), .done(done), .regA(regA), .regB(regB)
  );

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         dn;
    string        tag;
  } exp_t;
  exp_t expQ[$];

  // Reference state, built from the requirements
  logic [W-1:0] mA = '0, mB = '0;
  logic         mBusy = 1'b0;
  int           mLeft = 0;
  logic         mDone = 1'b0;

  // Monitor: one expected item per cycle, compared away from the edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (regA !== e.a || regB !== e.b || done !== e.dn) begin
        errors++;
        $display("FAIL %s: A=%b B=%b done=%b expected A=%b B=%b done=%b",
                 e.tag, regA, regB, done, e.a, e.b, e.dn);
      end
    end
  end

  task automatic cyc(input logic ld, input logic [W-1:0] la, input logic [W-1:0] lb,
                     input logic st, input string tag);
    exp_t e;
    @(negedge clk);
    load = ld; loadA = la; loadB = lb; start = st;
    @(posedge clk);
    mDone = 1'b0;
    if (mBusy) begin
      mB = {mA[0], mB[W-1:1]};
      mA = {mA[0], mA[W-1:1]};
      mLeft--;
      if (mLeft == 0) begin
        mBusy = 1'b0;
        mDone = 1'b1;
      end
    end else begin
      if (ld) begin mA = la; mB = lb; end
      if (st) begin mBusy = 1'b1; mLeft = W; end
    end
    #1;
    e.a = mA; e.b = mB; e.dn = mDone; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic doReset();
    exp_t e;
    @(negedge clk);
    rst = 1'b1; load = 1'b0; start = 1'b0;
    @(posedge clk);
    mA = '0; mB = '0; mBusy = 1'b0; mLeft = 0; mDone = 1'b0;
    #1;
    e.a = '0; e.b = '0; e.dn = 1'b0; e.tag = "R1 reset";
    expQ.push_back(e);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic direct(input logic ok, input string msg,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", msg, act, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    cyc(1'b1, 4'b1111, 4'b1111, 1'b0, "R2 load");
    doReset();

    // Known sequence from A=1011, B=0011
    cyc(1'b1, 4'b1011, 4'b0011, 1'b0, "R2 load idle");
    cyc(1'b0, '0, '0, 1'b1, "R5 start sampled");
    for (int k = 0; k < W; k++) cyc(1'b0, '0, '0, 1'b0, "R3 R4 R5 shift");
    cyc(1'b0, '0, '0, 1'b0, "R9 done single");
    cyc(1'b0, '0, '0, 1'b0, "R8 hold");
    @(negedge clk);
    direct(regB == 4'b1011, "R6 B copy", regB, 4'b1011);
    direct(regA == 4'b1011, "R6 A restored", regA, 4'b1011);

    // Start and load while busy are ignored
    cyc(1'b1, 4'b0110, 4'b1111, 1'b0, "R2 load");
    cyc(1'b0, '0, '0, 1'b1, "R5 start");
    cyc(1'b1, 4'b0000, 4'b0000, 1'b1, "R2 R7 load/start busy");
    cyc(1'b0, '0, '0, 1'b1, "R7 start busy");
    for (int k = 0; k < W; k++) cyc(1'b0, '0, '0, 1'b0, "R7 R5 finish");
    @(negedge clk);
    direct(regB == 4'b0110, "R6 after ignored start", regB, 4'b0110);

    // Load and start together, then a start on the done cycle
    cyc(1'b1, 4'b1001, 4'b0000, 1'b1, "R2 R5 load+start");
    for (int k = 0; k < W - 1; k++) cyc(1'b0, '0, '0, 1'b0, "R3 R4 shift");
    cyc(1'b0, '0, '0, 1'b0, "R5 last shift done");
    cyc(1'b0, '0, '0, 1'b1, "R9 start on done");
    for (int k = 0; k < W + 1; k++) cyc(1'b0, '0, '0, 1'b0, "R9 restart run");

    // Reset in the middle of a copy
    cyc(1'b1, 4'b1100, 4'b0101, 1'b0, "R2 load");
    cyc(1'b0, '0, '0, 1'b1, "R5 start");
    cyc(1'b0, '0, '0, 1'b0, "R3 shift");
    doReset();
    for (int k = 0; k < 3; k++) cyc(1'b0, '0, '0, 1'b0, "R1 R8 idle after reset");

    // Every source word over its complement
    for (int v = 0; v < 16; v++) begin
      cyc(1'b1, 4'(v), ~4'(v), 1'b0, "R2 sweep load");
      cyc(1'b0, '0, '0, 1'b1, "R5 sweep start");
      for (int k = 0; k < W; k++) cyc(1'b0, '0, '0, 1'b0, "R3 R4 sweep");
      @(negedge clk);
      direct(regB == 4'(v) && regA == 4'(v), "R6 sweep", regB, 4'(v));
    end

    cyc(1'b0, '0, '0, 1'b0, "R8 final");
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule